// File: doc/BRIEF.md
# Serial Receiver with Standby and Wakeup

This block is the receive side of an asynchronous serial port with a software-controlled standby mode. It samples the incoming line with a 16x oversampling tick and finds the start bit by its falling edge. It collects 8 or 9 data bits, least significant first, checks the stop bit, and moves each good character into a holding register. The holding register raises a full flag and a receive interrupt.

Software can put the receiver into standby. This is useful on a shared line where a node should ignore traffic addressed to other nodes. While in standby, the receive interrupt is masked and ordinary characters are thrown away. The hardware leaves standby by itself when it sees the selected wake condition. With the wake-select bit at 1, that condition is a character whose top data bit is set (an address mark). With the wake-select bit at 0, it is a full character time of idle line following a stop bit.

Top module: `serial_rx_wake`

## Requirements
- R1: Reset clears the receiver enable, the standby bit, the full flag and the interrupt output.
- R2: A control write (`ctl_wr` high) loads `rx_en` from `ctl_rx_en` only when `port_en` is 1. When `port_en` is 0, `rx_en` keeps its value.
- R3: Frame format: a falling edge on the line starts a frame, and the start bit is confirmed low at mid-bit (16 ticks per bit). Data bits follow, least significant first: 8 bits when `nine_bit`=0 and 9 bits when `nine_bit`=1. One stop bit, which must be high, ends the frame. In 8-bit mode `rx_data[8]` reads 0.
- R4: No character is taken in two cases: a start bit that reads high at its mid-point, and a stop bit that reads low.
- R5: Outside standby, a good character loads `rx_data` and sets `rx_full`. A one-cycle `data_rd` pulse clears `rx_full`. If a load and a read happen in the same cycle, the load wins.
- R6: While `rx_en` is 0, the line is ignored. Clearing `rx_en` leaves `rx_full` and `rx_data` unchanged.
- R7: `rx_irq` is high exactly when `rx_full` is 1 and `standby` is 0.
- R8: In standby, a character that does not cause a wakeup is not loaded and does not set `rx_full`.
- R9: With `wake_on_addr`=1, a character arriving in standby with its top data bit set wakes the receiver. The top bit is bit 7 in 8-bit mode and bit 8 in 9-bit mode. That character is loaded, `rx_full` is set, and `standby` is cleared.
- R10: With `wake_on_addr`=0, a continuous high line in standby, after a good stop bit, clears `standby`. The length is 10 bit times in 8-bit mode and 11 bit times in 9-bit mode. Nothing is loaded.
- R11: A control write loads `standby` from `ctl_standby` whatever the value of `port_en`. The write takes priority over a hardware wakeup in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Global port enable; gates writes to the receiver enable |
| ctl_wr | input | 1 | Control write strobe |
| ctl_rx_en | input | 1 | Receiver enable value to write |
| ctl_standby | input | 1 | Standby value to write |
| wake_on_addr | input | 1 | Wake select: 1 = address mark, 0 = idle line |
| nine_bit | input | 1 | 1 = 9 data bits, 0 = 8 data bits |
| baud_x16 | input | 1 | Oversampling tick, 16 per bit |
| rxd | input | 1 | Serial input line, idle high |
| data_rd | input | 1 | Read strobe for the holding register |
| rx_en | output | 1 | Receiver enable bit |
| standby | output | 1 | Standby bit |
| rx_data | output | 9 | Holding register |
| rx_full | output | 1 | Holding register full flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The checks look for the following faults:
- A standby bit that fails to clear shows up as an interrupt that never rises. It also shows up as a lost address character. Both are visible a few cycles after the wake character's stop bit, or one idle-frame time later.
- A wrong bit counter or sample point corrupts `rx_data` or drops the character. This is seen right after the stop bit.
- A broken idle counter either wakes too early, and is caught after a short gap between frames, or never wakes, and is caught after an 800-cycle idle wait.

// File: rtl/serial_rx_wake.sv
module serial_rx_wake #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic       ctl_wr,
  input  logic       ctl_rx_en,
  input  logic       ctl_standby,
  input  logic       wake_on_addr,
  input  logic       nine_bit,
  input  logic       baud_x16,
  input  logic       rxd,
  input  logic       data_rd,
  output logic       rx_en,
  output logic       standby,
  output logic [8:0] rx_data,
  output logic       rx_full,
  output logic       rx_irq
);
  localparam int CW  = $clog2(OSR);
  localparam int T8  = 10 * OSR;
  localparam int T9  = 11 * OSR;
  localparam int FRW = $clog2(T9 + 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;
  st_t            st;
  logic [1:0]     sync;
  logic           rx_q, armed;
  logic [CW-1:0]  cnt;
  logic [3:0]     bidx;
  logic [8:0]     sh;
  logic [FRW-1:0] icnt;

  wire rxs      = sync[1];
  wire mid      = cnt == CW'(OSR / 2 - 1);
  wire full_bit = cnt == CW'(OSR - 1);
  wire last_bit = bidx == (nine_bit ? 4'd8 : 4'd7);
  wire [FRW-1:0] ilim = nine_bit ? FRW'(T9 - 1) : FRW'(T8 - 1);
  wire msb      = nine_bit ? sh[8] : sh[7];

  wire char_ok  = rx_en && baud_x16 && st == S_STOP && full_bit && rxs;
  wire idle_hit = rx_en && baud_x16 && st == S_IDLE && armed && rxs &&
                  !(rx_q && !rxs) && icnt == ilim;
  wire wake_a   = char_ok && standby && wake_on_addr && msb;
  wire wake_i   = idle_hit && standby && !wake_on_addr;
  wire load     = char_ok && (!standby || wake_a);

  assign rx_irq = rx_full && !standby;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync <= 2'b11;
      rx_q <= 1'b1;
    end else begin
      sync <= {sync[0], rxd};
      if (baud_x16) rx_q <= rxs;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bidx <= '0; sh <= '0; armed <= 1'b0; icnt <= '0;
    end else if (!rx_en) begin
      st <= S_IDLE; cnt <= '0; armed <= 1'b0; icnt <= '0;
    end else if (baud_x16) begin
      case (st)
        S_IDLE:
          if (rx_q && !rxs) begin
            st <= S_START; cnt <= '0; icnt <= '0;
          end else if (armed && rxs) begin
            if (icnt == ilim) begin
              armed <= 1'b0; icnt <= '0;
            end else icnt <= icnt + 1'b1;
          end else icnt <= '0;
        S_START:
          if (mid) begin
            cnt <= '0;
            if (!rxs) begin st <= S_DATA; bidx <= '0; sh <= '0; end
            else st <= S_IDLE;
          end else cnt <= cnt + 1'b1;
        S_DATA:
          if (full_bit) begin
            cnt <= '0;
            sh[bidx] <= rxs;
            if (last_bit) st <= S_STOP;
            else bidx <= bidx + 1'b1;
          end else cnt <= cnt + 1'b1;
        default:
          if (full_bit) begin
            st <= S_IDLE; cnt <= '0; icnt <= '0;
            armed <= rxs;
          end else cnt <= cnt + 1'b1;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_en <= 1'b0; standby <= 1'b0; rx_full <= 1'b0; rx_data <= '0;
    end else begin
      if (ctl_wr && port_en) rx_en <= ctl_rx_en;
      if (ctl_wr) standby <= ctl_standby;
      else if (wake_a || wake_i) standby <= 1'b0;
      if (load) begin
        rx_full <= 1'b1;
        rx_data <= sh;
      end else if (data_rd) rx_full <= 1'b0;
    end

  // R2
  en_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |=> rx_en == $past(rx_en));
  // R6
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && !data_rd) |=> $stable(rx_full) && $stable(rx_data));
  // R8
  standby_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !wake_on_addr && !rx_full) |=> !rx_full);
  // R9
  addr_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(standby) && !$past(ctl_wr) && $past(wake_on_addr)) |-> rx_full);
endmodule

// File: tb/tb_serial_rx_wake.sv
module tb_serial_rx_wake;
  logic clk = 1'b0, rst_n = 1'b0;
  logic port_en = 1'b0, ctl_wr = 1'b0, ctl_rx_en = 1'b0, ctl_standby = 1'b0;
  logic wake_on_addr = 1'b0, nine_bit = 1'b0, rxd = 1'b1, data_rd = 1'b0;
  logic [1:0] tdiv = 2'd0;
  logic baud_x16;
  logic rx_en, standby, rx_full, rx_irq;
  logic [8:0] rx_data;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_x16 = tdiv == 2'd3;

  serial_rx_wake dut (.*);

  task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(bit en, bit sb);
    @(negedge clk); ctl_wr = 1'b1; ctl_rx_en = en; ctl_standby = sb;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
  endtask

  task automatic bitt(bit v);
    rxd = v;
    repeat (64) @(negedge clk);
  endtask

  task automatic send(logic [8:0] d, bit nine, bit stopv);
    bitt(1'b0);
    for (int i = 0; i < (nine ? 9 : 8); i++) bitt(d[i]);
    bitt(stopv);
    rxd = 1'b1;
    repeat (16) @(negedge clk);
  endtask

  function automatic bit top_bit(logic [8:0] d, bit nine);
    return nine ? d[8] : d[7];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1
    chk("R1 rx_en", rx_en, 0); chk("R1 standby", standby, 0);
    chk("R1 rx_full", rx_full, 0); chk("R1 rx_irq", rx_irq, 0);
    rst_n = 1'b1;
    // R2: write blocked while port disabled
    wr_ctl(1, 0);
    chk("R2 blocked", rx_en, 0);
    // R6: disabled receiver ignores line
    send(9'h055, 0, 1);
    chk("R6 ignored", rx_full, 0);
    port_en = 1'b1;
    wr_ctl(1, 0);
    chk("R2 accepted", rx_en, 1);
    repeat (20) @(negedge clk);
    // R3 / R5 / R7
    send(9'h0A5, 0, 1);
    chk("R5 full", rx_full, 1); chk("R3 data", rx_data, 9'h0A5);
    chk("R7 irq", rx_irq, 1);
    rd();
    chk("R5 read clears", rx_full, 0);
    nine_bit = 1'b1;
    send(9'h16B, 1, 1);
    chk("R3 nine data", rx_data, 9'h16B);
    rd();
    nine_bit = 1'b0;
    // R4 framing error and false start
    send(9'h033, 0, 0);
    repeat (64) @(negedge clk);
    chk("R4 framing", rx_full, 0);
    rxd = 1'b0; repeat (16) @(negedge clk); rxd = 1'b1;
    repeat (200) @(negedge clk);
    chk("R4 false start", rx_full, 0);
    // R6 clearing enable keeps flag
    send(9'h0C3, 0, 1);
    wr_ctl(0, 0);
    chk("R6 en off", rx_en, 0); chk("R6 keep full", rx_full, 1);
    chk("R6 keep data", rx_data, 9'h0C3);
    wr_ctl(1, 0);
    // R7 masked in standby
    wr_ctl(1, 1);
    chk("R7 masked", rx_irq, 0); chk("R11 standby set", standby, 1);
    wr_ctl(1, 0);
    chk("R7 unmasked", rx_irq, 1);
    rd();
    // R9 directed, nine-bit address mark
    nine_bit = 1'b1; wake_on_addr = 1'b1;
    wr_ctl(1, 1);
    send(9'h0FF, 1, 1);
    chk("R8 dropped", rx_full, 0); chk("R9 stays", standby, 1);
    send(9'h100, 1, 1);
    chk("R9 woke", standby, 0); chk("R9 loaded", rx_data, 9'h100);
    chk("R9 full", rx_full, 1);
    rd();
    // R10 directed
    nine_bit = 1'b0; wake_on_addr = 1'b0;
    wr_ctl(1, 1);
    send(9'h001, 0, 1);
    chk("R8 idle-mode drop", rx_full, 0); chk("R10 not yet", standby, 1);
    repeat (800) @(negedge clk);
    chk("R10 idle wake", standby, 0); chk("R10 nothing loaded", rx_full, 0);
    // random mix
    for (int it = 0; it < 40; it++) begin
      bit nine, ws, sb, efull, esb;
      logic [8:0] d;
      rd();
      nine = 1'($urandom % 2); ws = 1'($urandom % 2); sb = 1'($urandom % 2);
      d = 9'($urandom);
      if (!nine) d[8] = 1'b0;
      nine_bit = nine; wake_on_addr = ws;
      wr_ctl(1, sb);
      send(d, nine, 1);
      efull = !sb || (ws && top_bit(d, nine));
      esb = sb && !efull;
      chk("R5/R8 full", rx_full, efull);
      if (efull) chk("R3 data", rx_data, d);
      chk("R9 standby", standby, esb);
      chk("R7 irq", rx_irq, efull && !esb);
      if ($urandom % 4 == 0) begin
        repeat (800) @(negedge clk);
        chk("R10 standby", standby, esb && ws);
      end
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule